// File: doc/BRIEF.md
# Speculative Direct-Mapped Read Cache with Late Tag Verification

This block is the read path of a direct-mapped level-one data cache that bets on a hit. When a request is accepted, the data word stored at the indexed line is returned in the next cycle, with no tag check. The tag and valid bit of that line are compared in a separate stage. Its verdict appears one cycle after the data and carries the same request identifier, so the consumer can keep or discard the word it already received.

When the verdict is a miss, the block raises a request toward the next memory level, carrying the full line address. It stops accepting new requests until the next level returns the line over the refill port. The refill writes the tag, the data and the valid bit of that line, and the block then resumes.

Each line holds one word. The address splits into a low index field of `IDX_W` bits and an upper tag field. The fill controller is a three-state machine:

- **ST_RUN** accepts requests. It moves to ST_ISSUE when the tag check finds a miss.
- **ST_ISSUE** presents the miss request. It moves to ST_FILL on the handshake with `miss_ready`.
- **ST_FILL** waits for the line. It returns to ST_RUN when `refill_valid` arrives.

Top module: `spec_rd_cache`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In the following cycle `early_valid` is 1, `early_id` equals the accepted `req_id`, and `early_data` is the word stored at index `req_addr[IDX_W-1:0]`.
- R2: One cycle after `early_valid`, `verify_valid` is 1 with the same identifier. `verify_hit` is 1 exactly when the indexed line is valid and its stored tag equals `req_addr[ADDR_W-1:IDX_W]`.
- R3: When the stored tag of a valid line differs from the request tag, `early_data` still carries that line's stored word, and the verify result reports a miss.
- R4: In the cycle where the verify result reports a miss, `miss_valid` is 1 and `miss_addr` equals the full address of the missing request.
- R5: `req_ready` is 0 in the cycle where a missing request's data is returned. It stays 0 until the refill is taken, and it is 1 in the cycle after the refill edge.
- R6: A refill taken after the miss handshake stores `refill_data`, the tag and a set valid bit at the miss line. A later request to that address hits and returns `refill_data`.
- R7: `refill_valid` has no effect in ST_RUN or ST_ISSUE: no line changes, and no state changes.
- R8: Reset clears every valid bit and all output strobes, and it leaves `req_ready` at 1. The first access to any line after reset reports a miss.
- R9: Hits can be accepted on consecutive cycles, with one early response and one verify response per cycle.
- R10: While `miss_valid` is 1 and `miss_ready` is 0, `miss_valid` and `miss_addr` hold. After the handshake, `miss_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| req_id | input | ID_W | Request identifier |
| early_valid | output | 1 | Early data strobe |
| early_id | output | ID_W | Identifier of the early data |
| early_data | output | DATA_W | Word read from the indexed line before the tag check |
| verify_valid | output | 1 | Verify result strobe |
| verify_id | output | ID_W | Identifier of the verified request |
| verify_hit | output | 1 | 1 keeps the early data, 0 cancels it |
| miss_valid | output | 1 | Line request to the next level |
| miss_ready | input | 1 | Next level takes the line request |
| miss_addr | output | ADDR_W | Address of the missing line |
| refill_valid | input | 1 | Line data returned by the next level |
| refill_data | input | DATA_W | Returned word |

## Verification
Cold accesses after reset must all be cancelled, and refilled lines must then verify as hits with the refilled word. Together these two cases separate the valid-bit path from the tag compare. An access whose tag differs from that of a valid line on the same index shows that the early word comes from the indexed line regardless of the tag, and that the cancel tracks the tag compare alone. A burst of back-to-back hits checks that identifiers stay paired through the two stages. Slow handshakes on the miss port, with stray refill pulses in ST_RUN and ST_ISSUE, check the stall, the hold of the miss request, and that refills are taken only in ST_FILL.

// File: rtl/spec_cache_pkg.sv
package spec_cache_pkg;

    // Fill controller states
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,   // accepting requests
        ST_ISSUE = 2'd1,   // presenting a line request to the next level
        ST_FILL  = 2'd2    // waiting for the line to come back
    } fill_state_t;

endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld;

    // One valid bit per set, cleared by reset and set by a fill
    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic v;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                v <= 1'b1;
            end
        end
        assign vld[s] = v;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_tag   <= '0;
            rd_valid <= 1'b0;
        end else if (rd_en) begin
            rd_tag   <= tag_mem[rd_idx];
            rd_valid <= vld[rd_idx];
        end
    end

endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int SETS = 1 << IDX_W;

    logic [DATA_W-1:0] data_mem [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= data_mem[rd_idx];
        end
    end

endmodule

// File: rtl/sc_tag_check.sv
module sc_tag_check #(
    parameter int TAG_W = 8,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_valid,
    input  logic [ID_W-1:0]  s1_id,
    input  logic [TAG_W-1:0] s1_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             line_valid,
    output logic             miss_now,
    output logic             verify_valid,
    output logic [ID_W-1:0]  verify_id,
    output logic             verify_hit
);

    logic tag_eq;

    // Compare runs in the cycle after the data array read
    assign tag_eq   = line_valid && (line_tag == s1_tag);
    assign miss_now = s1_valid && !tag_eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verify_valid <= 1'b0;
            verify_id    <= '0;
            verify_hit   <= 1'b0;
        end else begin
            verify_valid <= s1_valid;
            if (s1_valid) begin
                verify_id  <= s1_id;
                verify_hit <= tag_eq;
            end
        end
    end

endmodule

// File: rtl/sc_fill_ctrl.sv
module sc_fill_ctrl
    import spec_cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_now,
    input  logic [ADDR_W-1:0]       miss_line,
    input  logic                    miss_ready,
    input  logic                    refill_valid,
    output logic                    run,
    output logic                    miss_valid,
    output logic [ADDR_W-1:0]       miss_addr,
    output logic                    fill_we,
    output logic [IDX_W-1:0]        fill_idx,
    output logic [ADDR_W-IDX_W-1:0] fill_tag
);

    fill_state_t state, nxt;
    logic [ADDR_W-1:0] line_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (miss_now)     nxt = ST_ISSUE;
            ST_ISSUE: if (miss_ready)   nxt = ST_FILL;
            ST_FILL:  if (refill_valid) nxt = ST_RUN;
            default:                    nxt = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        run        = 1'b0;
        miss_valid = 1'b0;
        fill_we    = 1'b0;
        unique case (state)
            ST_RUN:   run        = 1'b1;
            ST_ISSUE: miss_valid = 1'b1;
            ST_FILL:  fill_we    = refill_valid;
            default:  run        = 1'b0;
        endcase
    end

    // Line address of the missing request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if ((state == ST_RUN) && miss_now) begin
            line_q <= miss_line;
        end
    end

    assign miss_addr = line_q;
    assign fill_idx  = line_q[IDX_W-1:0];
    assign fill_tag  = line_q[ADDR_W-1:IDX_W];

endmodule

// File: rtl/spec_rd_cache.sv
module spec_rd_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    output logic              early_valid,
    output logic [ID_W-1:0]   early_id,
    output logic [DATA_W-1:0] early_data,
    output logic              verify_valid,
    output logic [ID_W-1:0]   verify_id,
    output logic              verify_hit,
    output logic              miss_valid,
    input  logic              miss_ready,
    output logic [ADDR_W-1:0] miss_addr,
    input  logic              refill_valid,
    input  logic [DATA_W-1:0] refill_data
);

    localparam int TAG_W = ADDR_W - IDX_W;

    logic              accept;
    logic              run;
    logic              miss_now;
    logic              s1_valid;
    logic [ID_W-1:0]   s1_id;
    logic [ADDR_W-1:0] s1_addr;
    logic [TAG_W-1:0]  line_tag;
    logic              line_valid;
    logic              fill_we;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;

    // A missing request in the compare stage blocks the next one
    assign req_ready = run && !miss_now;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_id    <= '0;
            s1_addr  <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_id   <= req_id;
                s1_addr <= req_addr;
            end
        end
    end

    sc_tag_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (accept),
        .rd_idx   (req_addr[IDX_W-1:0]),
        .rd_tag   (line_tag),
        .rd_valid (line_valid),
        .wr_en    (fill_we),
        .wr_idx   (fill_idx),
        .wr_tag   (fill_tag)
    );

    sc_data_store #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rd_en   (accept),
        .rd_idx  (req_addr[IDX_W-1:0]),
        .rd_data (early_data),
        .wr_en   (fill_we),
        .wr_idx  (fill_idx),
        .wr_data (refill_data)
    );

    sc_tag_check #(
        .TAG_W (TAG_W),
        .ID_W  (ID_W)
    ) u_check (
        .clk          (clk),
        .rst_n        (rst_n),
        .s1_valid     (s1_valid),
        .s1_id        (s1_id),
        .s1_tag       (s1_addr[ADDR_W-1:IDX_W]),
        .line_tag     (line_tag),
        .line_valid   (line_valid),
        .miss_now     (miss_now),
        .verify_valid (verify_valid),
        .verify_id    (verify_id),
        .verify_hit   (verify_hit)
    );

    sc_fill_ctrl #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_now     (miss_now),
        .miss_line    (s1_addr),
        .miss_ready   (miss_ready),
        .refill_valid (refill_valid),
        .run          (run),
        .miss_valid   (miss_valid),
        .miss_addr    (miss_addr),
        .fill_we      (fill_we),
        .fill_idx     (fill_idx),
        .fill_tag     (fill_tag)
    );

    assign early_valid = s1_valid;
    assign early_id    = s1_id;

endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
    parameter int ADDR_W = 12,
    parameter int ID_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ID_W-1:0]   req_id,
    input logic              early_valid,
    input logic [ID_W-1:0]   early_id,
    input logic              verify_valid,
    input logic [ID_W-1:0]   verify_id,
    input logic              verify_hit,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic [ADDR_W-1:0] miss_addr
);

    assert_early_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (early_valid && early_id == $past(req_id)));

    assert_verify_follows_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |=> (verify_valid && verify_id == $past(early_id)));

    assert_verify_needs_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        verify_valid |-> $past(early_valid));

    assert_miss_with_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_valid && !verify_hit) |-> miss_valid);

    assert_stall_during_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> !req_ready);

    assert_miss_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !miss_ready) |=> (miss_valid && $stable(miss_addr)));

    assert_miss_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_valid);

endmodule

bind spec_rd_cache sc_checker #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W)
) u_sc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_id       (req_id),
    .early_valid  (early_valid),
    .early_id     (early_id),
    .verify_valid (verify_valid),
    .verify_id    (verify_id),
    .verify_hit   (verify_hit),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .miss_addr    (miss_addr)
);

// File: tb/test_spec_rd_cache.sv
`timescale 1ns/1ps
module test_spec_rd_cache;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int ID_W   = 4;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int SETS   = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic              early_valid;
    logic [ID_W-1:0]   early_id;
    logic [DATA_W-1:0] early_data;
    logic              verify_valid;
    logic [ID_W-1:0]   verify_id;
    logic              verify_hit;
    logic              miss_valid;
    logic              miss_ready = 1'b0;
    logic [ADDR_W-1:0] miss_addr;
    logic              refill_valid = 1'b0;
    logic [DATA_W-1:0] refill_data = '0;

    always #2.5 clk = ~clk;

    spec_rd_cache #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .IDX_W (IDX_W), .ID_W (ID_W)
    ) i_spec_rd_cache (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_id (req_id),
        .early_valid (early_valid), .early_id (early_id), .early_data (early_data),
        .verify_valid (verify_valid), .verify_id (verify_id), .verify_hit (verify_hit),
        .miss_valid (miss_valid), .miss_ready (miss_ready), .miss_addr (miss_addr),
        .refill_valid (refill_valid), .refill_data (refill_data)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [ID_W-1:0]   id;
        logic              known;
        logic [DATA_W-1:0] data;
        logic              hit;
        string             label;
    } exp_t;

    exp_t              eq[$];
    exp_t              vq[$];
    logic [ADDR_W-1:0] mq[$];

    // Reference contents, updated only by refills the bench makes
    logic              m_vld [SETS];
    logic [TAG_W-1:0]  m_tag [SETS];
    logic [DATA_W-1:0] m_dat [SETS];

    int  miss_delay  = 0;
    bit  stray_issue = 0;
    int  cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [DATA_W-1:0] fill_word(input logic [ADDR_W-1:0] a);
        return {4'h5, a, 4'hA, ~a};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        miss_ready = 1'b0;
        refill_valid = 1'b0;
        eq.delete(); vq.delete(); mq.delete();
        for (int s = 0; s < SETS; s++) m_vld[s] = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state at the ports
        chk(req_ready == 1'b1, "R8 req_ready after reset", 64'(req_ready), 64'd1);
        chk(early_valid == 1'b0 && verify_valid == 1'b0, "R8 strobes after reset",
            64'({early_valid, verify_valid}), 64'd0);
        chk(miss_valid == 1'b0, "R8 miss_valid after reset", 64'(miss_valid), 64'd0);
    endtask

    // Driver: present a request, push expectations when it is taken
    task automatic issue(input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id, input string lbl);
        logic [IDX_W-1:0] ix;
        exp_t e;
        ix = a[IDX_W-1:0];
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_id    = id;
        while (!req_ready) @(negedge clk);
        e.id    = id;
        e.known = m_vld[ix];
        e.data  = m_dat[ix];
        e.hit   = m_vld[ix] && (m_tag[ix] == a[ADDR_W-1:IDX_W]);
        e.label = lbl;
        eq.push_back(e);
        vq.push_back(e);
        if (!e.hit) mq.push_back(a);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare responses
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (early_valid) begin
                    if (eq.size() == 0) begin
                        chk(0, "R1 unexpected early response", 64'(early_id), 64'd0);
                    end else begin
                        e = eq.pop_front();
                        chk(early_id == e.id, {e.label, " early_id"}, 64'(early_id), 64'(e.id));
                        if (e.known)
                            chk(early_data == e.data, {e.label, " early_data"}, 64'(early_data), 64'(e.data));
                        if (!e.hit)
                            chk(req_ready == 1'b0, "R5 stall in early cycle of miss", 64'(req_ready), 64'd0);
                    end
                end
                if (verify_valid) begin
                    if (vq.size() == 0) begin
                        chk(0, "R2 unexpected verify response", 64'(verify_id), 64'd0);
                    end else begin
                        e = vq.pop_front();
                        chk(verify_id == e.id, "R2 verify_id", 64'(verify_id), 64'(e.id));
                        chk(verify_hit == e.hit, {e.label, " R2 verify_hit"}, 64'(verify_hit), 64'(e.hit));
                    end
                end
            end
        end
    end

    // Next-level responder
    initial begin
        logic [ADDR_W-1:0] a;
        forever begin
            @(negedge clk);
            if (rst_n && miss_valid) begin
                chk(verify_valid && !verify_hit, "R4 miss raised with cancel",
                    64'({verify_valid, verify_hit}), 64'b10);
                a = (mq.size() > 0) ? mq.pop_front() : '0;
                chk(miss_addr == a, "R4 miss_addr", 64'(miss_addr), 64'(a));
                for (int k = 0; k < miss_delay; k++) begin
                    if (stray_issue && k == 0) begin
                        refill_valid = 1'b1;
                        refill_data  = 32'hDEAD_BEEF;
                    end else begin
                        refill_valid = 1'b0;
                    end
                    chk(!req_ready, "R5 stall while miss pending", 64'(req_ready), 64'd0);
                    @(negedge clk);
                    chk(miss_valid && miss_addr == a, "R10 miss held",
                        64'({miss_valid, miss_addr}), 64'({1'b1, a}));
                    if (stray_issue && k == 0)
                        chk(miss_valid, "R7 refill ignored before handshake", 64'(miss_valid), 64'd1);
                end
                refill_valid = 1'b0;
                miss_ready = 1'b1;
                @(negedge clk);
                miss_ready = 1'b0;
                chk(!miss_valid, "R10 miss drops after handshake", 64'(miss_valid), 64'd0);
                chk(!req_ready, "R5 stall while waiting for line", 64'(req_ready), 64'd0);
                @(negedge clk);
                refill_valid = 1'b1;
                refill_data  = fill_word(a);
                m_vld[a[IDX_W-1:0]] = 1'b1;
                m_tag[a[IDX_W-1:0]] = a[ADDR_W-1:IDX_W];
                m_dat[a[IDX_W-1:0]] = fill_word(a);
                @(negedge clk);
                refill_valid = 1'b0;
                chk(req_ready, "R5 resume after refill", 64'(req_ready), 64'd1);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t0;
        do_reset();

        // R8: cold line misses; R6: refill then hit
        issue(12'h012, 4'd1, "R8 cold");
        idle(10);
        issue(12'h012, 4'd2, "R6 refilled");
        idle(4);

        // Fill several lines, each a miss
        for (int i = 0; i < 6; i++) begin
            issue({8'h40, 4'(i)}, 4'(i), "R8 cold set");
            idle(10);
        end

        // R9: back-to-back hits
        @(negedge clk);
        t0 = cyc;
        for (int i = 0; i < 6; i++) issue({8'h40, 4'(i)}, 4'(i + 8), "R9 burst");
        chk(cyc - t0 == 6, "R9 one accept per cycle", 64'(cyc - t0), 64'd6);
        idle(4);

        // R3: other tag on a valid line
        issue(12'h072, 4'd3, "R3 tag mismatch");
        idle(10);
        issue(12'h402, 4'd4, "R3 evicted line");
        idle(10);

        // R10 with slow handshake, plus stray refill in ST_ISSUE (R7)
        miss_delay  = 3;
        stray_issue = 1;
        issue(12'h0A5, 4'd5, "R10 slow miss");
        idle(14);
        miss_delay  = 0;
        stray_issue = 0;

        // R7: stray refill in ST_RUN leaves lines unchanged
        @(negedge clk);
        refill_valid = 1'b1;
        refill_data  = 32'h1234_5678;
        @(negedge clk);
        refill_valid = 1'b0;
        issue(12'h0A5, 4'd6, "R7 stray refill");
        idle(4);

        // R8: reset in mid run clears valid bits
        do_reset();
        issue(12'h0A5, 4'd7, "R8 after reset");
        idle(10);
        issue(12'h0A5, 4'd8, "R6 refill after reset");
        idle(4);

        chk(eq.size() == 0 && vq.size() == 0, "R2 all responses seen",
            64'(eq.size() + vq.size()), 64'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule